// File: doc/BRIEF.md
# Serial NOR Flash Command Controller

This block sits on a processor's byte-wide peripheral bus and turns a handful of register writes into complete serial NOR flash transactions. Software loads a transmit byte and the middle and low address bytes, then writes an opcode into the command register. The controller lowers chip select, shifts out the opcode and whatever address and dummy bytes that opcode needs, moves the data bytes, and raises chip select again. Received bytes and two status flags come back through the same four-location register window.

The most significant address byte is not writable. It is always the topmost sector number (a parameter, 0x0F by default), so software can only reach that sector. The controller never adds a write-enable by itself. Software must issue write-enable before a program, erase or status-write command.

Read, fast read and page program are open-ended streams. Once the header bytes have gone out, chip select stays low. During a read stream, each read of the receive register starts the next byte fetch. During a page-program stream, each write of the transmit register sends one byte, up to the end of the current page. Writing the end value 0x00 to the command register closes the stream.

Top module: `spi_flash_ctrl`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and the status byte (offset 1) reads 0x00.
- R2: The register window is as follows. Offset 0 is the transmit byte on write and the receive byte on read. Offset 1 is the command on write and the status on read. Offset 2 is the middle address byte and offset 3 is the low address byte, both written by software. In the status byte, bit 0 is busy and bit 1 is receive-valid. Busy is 1 while a byte is shifting or chip select is in its recovery time. Receive-valid is set when a received byte is loaded and cleared when offset 0 is read.
- R3: Write enable (0x06), write disable (0x04) and bulk erase (0xC7) each produce one chip-select frame holding only the opcode byte.
- R4: Sector erase (0xD8) sends, in this order, the opcode, the fixed top byte 0x0F, the middle byte and the low byte, and then ends the frame.
- R5: Write status (0x01) sends the opcode and then the transmit register. Read status (0x05) sends the opcode and one 0x00 byte, and stores the byte received during that second byte as receive data.
- R6: Read signature (0xAB) sends the opcode and three 0x00 dummy bytes. It then clocks one more byte and stores what comes back during that fifth byte as receive data.
- R7: Read (0x03) sends the opcode, 0x0F, the middle byte and the low byte. It then fetches one data byte by itself. Each read of offset 0 while the controller is idle in the open stream fetches one more byte. Chip select stays low until command 0x00 is written.
- R8: Fast read (0x0B) behaves as read but puts one 0x00 dummy byte after the address. The first data byte is therefore the sixth byte of the frame.
- R9: Page program (0x02) sends the four header bytes. After that, each offset-0 write sends its byte, until the page of `PAGE_BYTES` bytes ends. The number of bytes allowed is `PAGE_BYTES` minus the page offset of the address. Further transmit writes send nothing and leave busy at 0.
- R10: A command write is ignored if its value is not one of the opcodes above, or if it arrives while busy is 1. No frame starts and nothing else changes.
- R11: The SPI runs in mode 0. `spi_sclk` is low whenever chip select is high. `spi_mosi` only changes while `spi_sclk` is low. The SCLK period is `CLK_DIV` system clocks.
- R12: Chip select stays high for at least 2×`CLK_DIV` system clocks between frames. Busy stays 1 for that whole recovery time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed offset (combinational) |
| spi_sclk | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Each byte takes 8×`CLK_DIV` system clocks. A frame closes 2×`CLK_DIV`+1 clocks after its last byte. Because of this, the bench never waits a fixed number of cycles. After each command, transmit write or receive read it polls the busy bit and compares results only once busy reads 0. By then chip select has risen for fixed-length commands, or the stream is parked with its data loaded. A behavioural flash model in the bench records every frame, byte by byte, and answers each byte position with a known pattern, so the expected receive values follow from the byte index the requirements give. Ignored stimulus is checked by reading status on the very next access, and by confirming that the frame count has not moved.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_SE    = 8'hD8;
    localparam logic [7:0] OP_BE    = 8'hC7;
    localparam logic [7:0] OP_RES   = 8'hAB;
    localparam logic [7:0] CMD_END  = 8'h00;

    // What happens after the header bytes
    typedef enum logic [2:0] {
        TL_NONE,   // close frame
        TL_TX,     // send transmit register, close
        TL_RX,     // clock one byte in, close
        TL_RDS,    // open read stream
        TL_WRS     // open program stream
    } tail_e;

    typedef struct packed {
        logic       valid;
        logic       has_addr;
        logic [2:0] hdr_len;   // bytes including opcode
        tail_e      tail;
    } cmd_info_t;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_TAIL, S_XFER, S_WAIT, S_GUARD
    } seq_e;

    function automatic cmd_info_t decode_cmd(input logic [7:0] op);
        cmd_info_t ci;
        ci = '{valid: 1'b1, has_addr: 1'b0, hdr_len: 3'd1, tail: TL_NONE};
        case (op)
            OP_WREN, OP_WRDI, OP_BE: ci.tail = TL_NONE;
            OP_RDSR: ci.tail = TL_RX;
            OP_WRSR: ci.tail = TL_TX;
            OP_READ: begin ci.has_addr = 1'b1; ci.hdr_len = 3'd4; ci.tail = TL_RDS; end
            OP_FAST: begin ci.has_addr = 1'b1; ci.hdr_len = 3'd5; ci.tail = TL_RDS; end
            OP_PP:   begin ci.has_addr = 1'b1; ci.hdr_len = 3'd4; ci.tail = TL_WRS; end
            OP_SE:   begin ci.has_addr = 1'b1; ci.hdr_len = 3'd4; ci.tail = TL_NONE; end
            OP_RES:  begin ci.hdr_len = 3'd4; ci.tail = TL_RX; end
            default: ci.valid = 1'b0;
        endcase
        return ci;
    endfunction

endpackage

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done,
    output logic       active
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;
    logic          samp;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sclk   <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            sh     <= '0;
            samp   <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh     <= tx;
                active <= 1'b1;
                sclk   <= 1'b0;
                cnt    <= '0;
                bitn   <= '0;
            end else if (active) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                        samp <= miso;
                    end else begin
                        sclk <= 1'b0;
                        sh   <= {sh[6:0], samp};
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                            rx     <= {sh[6:0], samp};
                        end else begin
                            bitn <= bitn + 3'd1;
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sfc_regs.sv
module sfc_regs (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rx_load,
    input  logic [7:0] rx_byte,
    input  logic       busy,
    output logic [7:0] tx_q,
    output logic [7:0] mid_q,
    output logic [7:0] lo_q,
    output logic       cmd_wr,
    output logic       tx_wr,
    output logic       rx_rd
);
    logic [7:0] rx_q;
    logic       rx_valid;

    assign cmd_wr = sel &&  we && (addr == 2'd1);
    assign tx_wr  = sel &&  we && (addr == 2'd0);
    assign rx_rd  = sel && !we && (addr == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= '0;
            mid_q    <= '0;
            lo_q     <= '0;
            rx_q     <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (sel && we) begin
                case (addr)
                    2'd0: tx_q  <= wdata;
                    2'd2: mid_q <= wdata;
                    2'd3: lo_q  <= wdata;
                    default: ;
                endcase
            end
            if (rx_load) begin
                rx_q     <= rx_byte;
                rx_valid <= 1'b1;
            end else if (rx_rd) begin
                rx_valid <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            2'd0:    rdata = rx_q;
            2'd1:    rdata = {6'b0, rx_valid, busy};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int         CLK_DIV    = 4,
    parameter int         PAGE_BYTES = 256,
    parameter logic [7:0] TOP_SECTOR = 8'h0F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic       tx_wr,
    input  logic       rx_rd,
    input  logic [7:0] wdata,
    input  logic [7:0] tx_q,
    input  logic [7:0] mid_q,
    input  logic [7:0] lo_q,
    input  logic       sh_done,
    output logic       sh_start,
    output logic [7:0] sh_tx,
    output logic       rx_load,
    output logic       cs_n,
    output logic       busy
);
    localparam int PW        = $clog2(PAGE_BYTES);
    localparam int GUARD_CYC = 2 * CLK_DIV;
    localparam int GW        = $clog2(GUARD_CYC) + 1;

    seq_e       st;
    cmd_info_t  info_q;
    cmd_info_t  info_in;
    logic [7:0] op_q;
    logic [2:0] idx;
    logic [PW:0] rem;
    logic [GW-1:0] gcnt;
    logic [15:0] addr16;
    logic [PW:0] page_left;
    logic        end_req;

    assign info_in   = decode_cmd(wdata);
    assign addr16    = {mid_q, lo_q};
    assign page_left = (PW+1)'(PAGE_BYTES) - {1'b0, addr16[PW-1:0]};
    assign end_req   = cmd_wr && (wdata == CMD_END);

    function automatic logic [7:0] hdr_byte(input logic [2:0] i, input logic ha);
        case (i)
            3'd1:    return ha ? TOP_SECTOR : 8'h00;
            3'd2:    return ha ? mid_q      : 8'h00;
            3'd3:    return ha ? lo_q       : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cs_n   <= 1'b1;
            info_q <= '0;
            op_q   <= '0;
            idx    <= '0;
            rem    <= '0;
            gcnt   <= '0;
        end else begin
            case (st)
                S_IDLE: if (cmd_wr && info_in.valid) begin
                    cs_n   <= 1'b0;
                    info_q <= info_in;
                    op_q   <= wdata;
                    idx    <= 3'd1;
                    rem    <= page_left;
                    st     <= S_HDR;
                end
                S_HDR: if (sh_done) begin
                    if (idx < info_q.hdr_len) begin
                        idx <= idx + 3'd1;
                    end else begin
                        case (info_q.tail)
                            TL_TX, TL_RX: st <= S_TAIL;
                            TL_RDS:       st <= S_XFER;
                            TL_WRS:       st <= S_WAIT;
                            default: begin
                                cs_n <= 1'b1;
                                gcnt <= '0;
                                st   <= S_GUARD;
                            end
                        endcase
                    end
                end
                S_TAIL: if (sh_done) begin
                    cs_n <= 1'b1;
                    gcnt <= '0;
                    st   <= S_GUARD;
                end
                S_XFER: if (sh_done) st <= S_WAIT;
                S_WAIT: begin
                    if (end_req) begin
                        cs_n <= 1'b1;
                        gcnt <= '0;
                        st   <= S_GUARD;
                    end else if (info_q.tail == TL_RDS && rx_rd) begin
                        st <= S_XFER;
                    end else if (info_q.tail == TL_WRS && tx_wr && rem != '0) begin
                        rem <= rem - 1'b1;
                        st  <= S_XFER;
                    end
                end
                S_GUARD: begin
                    gcnt <= gcnt + 1'b1;
                    if (gcnt == GW'(GUARD_CYC - 1)) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        case (st)
            S_IDLE: if (cmd_wr && info_in.valid) begin
                sh_start = 1'b1;
                sh_tx    = wdata;
            end
            S_HDR: if (sh_done) begin
                if (idx < info_q.hdr_len) begin
                    sh_start = 1'b1;
                    sh_tx    = hdr_byte(idx, info_q.has_addr);
                end else if (info_q.tail == TL_TX) begin
                    sh_start = 1'b1;
                    sh_tx    = tx_q;
                end else if (info_q.tail == TL_RX || info_q.tail == TL_RDS) begin
                    sh_start = 1'b1;
                end
            end
            S_WAIT: if (!end_req) begin
                if (info_q.tail == TL_RDS && rx_rd) begin
                    sh_start = 1'b1;
                end else if (info_q.tail == TL_WRS && tx_wr && rem != '0) begin
                    sh_start = 1'b1;
                    sh_tx    = wdata;
                end
            end
            default: ;
        endcase
    end

    assign rx_load = sh_done && ((st == S_TAIL && info_q.tail == TL_RX) ||
                                 (st == S_XFER && info_q.tail == TL_RDS));
    assign busy    = (st == S_HDR) || (st == S_TAIL) || (st == S_XFER) || (st == S_GUARD);

    logic unused_op;
    assign unused_op = ^op_q;
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl #(
    parameter int         CLK_DIV    = 4,
    parameter int         PAGE_BYTES = 256,
    parameter logic [7:0] TOP_SECTOR = 8'h0F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_sel,
    input  logic       cpu_we,
    input  logic [1:0] cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic [7:0] tx_q, mid_q, lo_q, sh_tx, sh_rx;
    logic cmd_wr, tx_wr, rx_rd, rx_load, busy_w;
    logic sh_start, sh_done, sh_active;

    sfc_regs u_regs (
        .clk(clk), .rst(rst), .sel(cpu_sel), .we(cpu_we), .addr(cpu_addr),
        .wdata(cpu_wdata), .rdata(cpu_rdata), .rx_load(rx_load), .rx_byte(sh_rx),
        .busy(busy_w), .tx_q(tx_q), .mid_q(mid_q), .lo_q(lo_q),
        .cmd_wr(cmd_wr), .tx_wr(tx_wr), .rx_rd(rx_rd)
    );

    sfc_seq #(.CLK_DIV(CLK_DIV), .PAGE_BYTES(PAGE_BYTES), .TOP_SECTOR(TOP_SECTOR)) u_seq (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .tx_wr(tx_wr), .rx_rd(rx_rd),
        .wdata(cpu_wdata), .tx_q(tx_q), .mid_q(mid_q), .lo_q(lo_q),
        .sh_done(sh_done), .sh_start(sh_start), .sh_tx(sh_tx),
        .rx_load(rx_load), .cs_n(spi_cs_n), .busy(busy_w)
    );

    sfc_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .rx(sh_rx), .done(sh_done), .active(sh_active)
    );

    logic unused_act;
    assign unused_act = sh_active;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic spi_sclk,
    input logic spi_cs_n,
    input logic spi_mosi,
    input logic busy
);
    localparam int GAP_MIN = 2 * CLK_DIV;
    localparam int GW      = $clog2(GAP_MIN + 1) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)                                 gap_q <= GW'(GAP_MIN);
        else if (!spi_cs_n)                      gap_q <= '0;
        else if (gap_q < GW'(GAP_MIN))           gap_q <= gap_q + 1'b1;
    end

    // R11: clock parked low while deselected
    a_r11_idle_low: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R11: data held across the sampling edge
    a_r11_mosi_setup: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    // R12: minimum deselect time
    a_r12_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (gap_q >= GW'(GAP_MIN)));

    // R12: busy covers the recovery time
    a_r12_busy_guard: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> busy);

    // R2: no clocking unless busy
    a_r2_busy_clocking: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> busy);
endmodule

bind spi_flash_ctrl sfc_checker #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .busy(busy_w)
);

// File: tb/spi_flash_ctrl_tb.sv
module spi_flash_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;

    logic clk = 0, rst = 1;
    logic cpu_sel = 0, cpu_we = 0;
    logic [1:0] cpu_addr = 0;
    logic [7:0] cpu_wdata = 0, cpu_rdata;
    logic spi_sclk, spi_cs_n, spi_mosi;
    logic spi_miso = 0;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_flash_ctrl u_dut (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    function automatic logic [7:0] fpat(input int k);
        return 8'h3C ^ 8'((k * 17) & 255);
    endfunction

    logic [7:0] cap [16];
    logic [7:0] shin;
    int bitc = 0, byc = 0, frame_len = 0, frames = 0;
    int rise_cyc = 0, min_gap = 1000, last_sck = -1, sck_period = 0;
    bit had_rise = 0;

    always @(negedge spi_cs_n) begin
        bitc = 0; byc = 0; last_sck = -1;
        spi_miso = fpat(0)[7];
        if (had_rise && (cyc - rise_cyc) < min_gap) min_gap = cyc - rise_cyc;
    end
    always @(posedge spi_cs_n) begin
        if (!rst) begin
            frame_len = byc; frames++; rise_cyc = cyc; had_rise = 1;
        end
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        shin = {shin[6:0], spi_mosi};
        if (last_sck >= 0) sck_period = cyc - last_sck;
        last_sck = cyc;
        bitc++;
        if (bitc == 8) begin
            if (byc < 16) cap[byc] = shin;
            bitc = 0; byc++;
        end
    end
    always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = fpat(byc)[7 - bitc];

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_sel = 0; cpu_we = 0;
    endtask

    task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(posedge clk); #1;
        cpu_sel = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            cpu_rd(2'd1, s);
            if (!s[0]) break;
        end
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  tx;
        logic [7:0]  mid;
        logic [7:0]  lo;
        logic [3:0]  len;
        logic [39:0] bytes;
        logic        chk_rx;
        logic [7:0]  rx;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h06, 8'h00, 8'h00, 8'h00, 4'd1, 40'h06_00_00_00_00, 1'b0, 8'h00}, // R3
        '{8'h04, 8'h00, 8'h00, 8'h00, 4'd1, 40'h04_00_00_00_00, 1'b0, 8'h00}, // R3
        '{8'hC7, 8'h00, 8'h00, 8'h00, 4'd1, 40'hC7_00_00_00_00, 1'b0, 8'h00}, // R3
        '{8'hD8, 8'h00, 8'h12, 8'h34, 4'd4, 40'hD8_0F_12_34_00, 1'b0, 8'h00}, // R4
        '{8'h01, 8'h9C, 8'h00, 8'h00, 4'd2, 40'h01_9C_00_00_00, 1'b0, 8'h00}, // R5
        '{8'h05, 8'h00, 8'h00, 8'h00, 4'd2, 40'h05_00_00_00_00, 1'b1, 8'h2D}, // R5
        '{8'hAB, 8'h00, 8'h55, 8'h66, 4'd5, 40'hAB_00_00_00_00, 1'b1, 8'h78}, // R6
        '{8'h9F, 8'h00, 8'h00, 8'h00, 4'd0, 40'h00_00_00_00_00, 1'b0, 8'h00}  // R10
    };

    bit done_flag = 0;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int f0;
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);

        // R1 reset state
        check(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
        check(spi_sclk === 1'b0, "R1 sclk", spi_sclk, 0);
        cpu_rd(2'd1, d);
        check(d === 8'h00, "R1 status", d, 0);

        // table walk: R3 R4 R5 R6 R10
        foreach (VECS[v]) begin
            f0 = frames;
            cpu_wr(2'd0, VECS[v].tx);
            cpu_wr(2'd2, VECS[v].mid);
            cpu_wr(2'd3, VECS[v].lo);
            cpu_wr(2'd1, VECS[v].cmd);
            if (VECS[v].len != 0) begin
                cpu_rd(2'd1, d);
                check(d[0] === 1'b1, "R2 busy set", d, 1);
            end
            wait_idle();
            check(frames - f0 == ((VECS[v].len != 0) ? 1 : 0), "R3/R10 frame count", frames - f0, (VECS[v].len != 0) ? 1 : 0);
            if (VECS[v].len != 0) begin
                check(frame_len == int'(VECS[v].len), "R4 frame length", frame_len, VECS[v].len);
                for (int b = 0; b < int'(VECS[v].len); b++)
                    check(cap[b] === VECS[v].bytes[39 - 8*b -: 8], "R4/R5/R6 wire byte", cap[b], VECS[v].bytes[39 - 8*b -: 8]);
            end
            if (VECS[v].chk_rx) begin
                cpu_rd(2'd1, d);
                check(d[1] === 1'b1, "R2 rx valid", d, 2);
                cpu_rd(2'd0, d);
                check(d === VECS[v].rx, "R5/R6 rx data", d, VECS[v].rx);
                cpu_rd(2'd1, d);
                check(d[1] === 1'b0, "R2 rx valid cleared", d, 0);
            end
        end

        // R11 SCLK period
        check(sck_period == DIV, "R11 sclk period", sck_period, DIV);

        // R7 read stream
        f0 = frames;
        cpu_wr(2'd2, 8'h20); cpu_wr(2'd3, 8'h40);
        cpu_wr(2'd1, 8'h03);
        wait_idle();
        check(spi_cs_n === 1'b0, "R7 cs held low", spi_cs_n, 0);
        cpu_rd(2'd1, d);
        check(d === 8'h02, "R7 status in stream", d, 2);
        cpu_rd(2'd0, d);
        check(d === fpat(4), "R7 first data", d, fpat(4));
        wait_idle();
        cpu_rd(2'd0, d);
        check(d === fpat(5), "R7 second data", d, fpat(5));
        wait_idle();
        check(frames == f0, "R7 no frame end yet", frames - f0, 0);
        cpu_wr(2'd1, 8'h00);
        wait_idle();
        check(spi_cs_n === 1'b1, "R7 end raises cs", spi_cs_n, 1);
        check(frame_len == 7, "R7 frame length", frame_len, 7);
        check(cap[1] === 8'h0F && cap[2] === 8'h20 && cap[3] === 8'h40, "R7 address bytes",
              {cap[1], cap[2], cap[3]}, 24'h0F2040);

        // R8 fast read
        cpu_wr(2'd1, 8'h0B);
        wait_idle();
        cpu_rd(2'd0, d);
        check(d === fpat(5), "R8 first data after dummy", d, fpat(5));
        wait_idle();
        cpu_wr(2'd1, 8'h00);
        wait_idle();
        check(frame_len == 7 && cap[4] === 8'h00, "R8 frame with dummy", frame_len, 7);

        // R9 page program at page edge: 0x00FE leaves 2 bytes
        cpu_wr(2'd2, 8'h00); cpu_wr(2'd3, 8'hFE);
        cpu_wr(2'd1, 8'h02);
        wait_idle();
        cpu_wr(2'd0, 8'hA1); wait_idle();
        cpu_wr(2'd0, 8'hB2); wait_idle();
        cpu_wr(2'd0, 8'hC3);
        cpu_rd(2'd1, d);
        check(d[0] === 1'b0, "R9 extra byte ignored busy", d, 0);
        cpu_wr(2'd1, 8'h00);
        wait_idle();
        check(frame_len == 6, "R9 frame length", frame_len, 6);
        check(cap[4] === 8'hA1 && cap[5] === 8'hB2, "R9 data bytes", {cap[4], cap[5]}, 16'hA1B2);

        // R10 command while busy; R12 back-to-back gap
        f0 = frames;
        cpu_wr(2'd1, 8'h06);
        cpu_wr(2'd1, 8'h04);
        wait_idle();
        check(frames - f0 == 1 && cap[0] === 8'h06, "R10 busy command ignored", frames - f0, 1);
        cpu_wr(2'd1, 8'h04);
        wait_idle();
        check(cap[0] === 8'h04, "R3 follow-up frame", cap[0], 8'h04);
        check(min_gap >= 2*DIV, "R12 cs high gap", min_gap, 2*DIV);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule